// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Tracker

This block sits beside the retirement stage of a core and follows the stream of retired instructions. Each indirect call or indirect jump arms the tracker. The next valid instruction must then be the landing-pad marker for the current operating width. If it is, the tracker disarms. If it is anything else, the tracker raises a control-protection fault.

The comparison is a plain equality test on the first four opcode bytes. It uses no key and no signature, so any landing pad satisfies the check, not only the one the branch was aimed at. Direct transfers and returns never arm the tracker; returns are covered by a separate return-address checker. When tracking is switched off, the marker behaves as an ordinary no-op and the block never faults.

The core presents one instruction per cycle through a valid flag, a branch-kind code and the opcode bytes. It reads back a one-cycle fault pulse and the armed state.

Top module: `lpad_tracker`

## Requirements
- R1: With tracking enabled and the tracker idle, a valid instruction of kind indirect call (3) or indirect jump (4) makes `armed` read 1 on the cycle after it.
- R2: While armed, a valid instruction whose opcode bytes equal the width's marker clears `armed` on the next cycle without a fault. In 64-bit mode (`mode32`=0) the marker is byte 0 = F3, byte 1 = 0F, byte 2 = 1E, byte 3 = FA, where byte k is `op_bytes[8k+7:8k]`.
- R3: While armed, any valid instruction that is not the marker raises `cp_fault` on the next cycle. This holds even when that instruction is itself an indirect branch.
- R4: Direct call (1) and direct jump (2) never arm the tracker.
- R5: Return (5) and other (0) never arm the tracker, and are not checked when idle.
- R6: In 32-bit mode (`mode32`=1) the marker is F3 0F 1E FB. In this mode the 64-bit marker does not satisfy an armed tracker and faults, and the reverse also holds.
- R7: With `track_en`=0, `cp_fault` stays 0 and `armed` reads 0 on the following cycle. A marker executed while idle, or while tracking is disabled, has no effect.
- R8: A cycle with `ins_valid`=0 leaves `armed` unchanged and raises no fault.
- R9: `cp_fault` lasts exactly one cycle, and the tracker is idle (`armed`=0) while it is high.
- R10: After reset, `armed` and `cp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_en | input | 1 | Enables landing-pad enforcement |
| mode32 | input | 1 | 1 selects the 32-bit marker encoding |
| ins_valid | input | 1 | A retired instruction is presented this cycle |
| ins_kind | input | 3 | Branch kind: 0 other, 1 direct call, 2 direct jump, 3 indirect call, 4 indirect jump, 5 return |
| op_bytes | input | 32 | First four opcode bytes; byte 0 in bits 7:0 |
| cp_fault | output | 1 | One-cycle control-protection fault pulse |
| armed | output | 1 | Tracker is waiting for a landing pad |

## Verification
Directed sequences pair each branch kind with each marker encoding and with random opcode bytes, in both widths. These separate arming from non-arming kinds and show that the exact-width match decides between a clean landing and a fault. Bubbles inserted between an arming branch and its target show that the wait survives idle cycles. Back-to-back indirect branches show that a second branch in the armed state faults instead of re-arming. A long random run then mixes all kinds, markers, bubbles, enable toggles and width changes, and compares every cycle against a reference model in the bench.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int OP_W   = 32;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER    = 3'd0,
    K_DCALL    = 3'd1,
    K_DJMP     = 3'd2,
    K_ICALL    = 3'd3,
    K_IJMP     = 3'd4,
    K_RET      = 3'd5
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } trk_state_e;

  // marker bytes, byte 0 in the low bits
  localparam logic [OP_W-1:0] PAD_W64 = 32'hFA1E0FF3;
  localparam logic [OP_W-1:0] PAD_W32 = 32'hFB1E0FF3;

  function automatic logic [OP_W-1:0] pad_for(input logic is32);
    return is32 ? PAD_W32 : PAD_W64;
  endfunction

  function automatic logic is_fwd_indirect(input logic [KIND_W-1:0] k);
    return (k == K_ICALL) || (k == K_IJMP);
  endfunction
endpackage

// File: rtl/lpad_match.sv
module lpad_match
  import lpad_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int W = BYTES * 8
) (
  input  logic [W-1:0] op,
  input  logic         is32,
  output logic         hit
);
  logic [W-1:0] want;
  logic [BYTES-1:0] byte_eq;
  assign want = pad_for(is32);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_eq[b] = (op[8*b +: 8] == want[8*b +: 8]);
  end
  assign hit = &byte_eq;
endmodule

// File: rtl/lpad_arm_decode.sv
module lpad_arm_decode
  import lpad_pkg::*;
(
  input  logic              valid,
  input  logic              en,
  input  logic [KIND_W-1:0] kind,
  output logic              arm_req
);
  assign arm_req = en && valid && is_fwd_indirect(kind);
endmodule

// File: rtl/lpad_fsm.sv
module lpad_fsm
  import lpad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic valid,
  input  logic arm_req,
  input  logic pad_hit,
  output logic waiting,
  output logic fault,
  output logic land_ok,
  output logic land_bad
);
  trk_state_e st_q, st_d;
  logic       fault_q, fault_d;

  assign land_ok  = en && valid && (st_q == ST_WAIT) && pad_hit;
  assign land_bad = en && valid && (st_q == ST_WAIT) && !pad_hit;

  always_comb begin
    st_d    = st_q;
    fault_d = 1'b0;
    if (!en) begin
      st_d = ST_IDLE;
    end else if (valid) begin
      unique case (st_q)
        ST_IDLE: if (arm_req) st_d = ST_WAIT;
        ST_WAIT: begin
          st_d    = ST_IDLE;
          fault_d = land_bad;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
    end
  end

  assign waiting = (st_q == ST_WAIT);
  assign fault   = fault_q;
endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
  import lpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track_en,
  input  logic              mode32,
  input  logic              ins_valid,
  input  logic [KIND_W-1:0] ins_kind,
  input  logic [OP_W-1:0]   op_bytes,
  output logic              cp_fault,
  output logic              armed
);
  logic arm_req, pad_hit, land_ok, land_bad;

  lpad_arm_decode u_dec (
    .valid(ins_valid), .en(track_en), .kind(ins_kind), .arm_req(arm_req)
  );

  lpad_match #(.BYTES(OP_W/8)) u_match (
    .op(op_bytes), .is32(mode32), .hit(pad_hit)
  );

  lpad_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(track_en), .valid(ins_valid),
    .arm_req(arm_req), .pad_hit(pad_hit),
    .waiting(armed), .fault(cp_fault),
    .land_ok(land_ok), .land_bad(land_bad)
  );
endmodule

// File: rtl/lpad_tracker_chk.sv
module lpad_tracker_chk
  import lpad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              track_en,
  input logic              mode32,
  input logic              ins_valid,
  input logic [KIND_W-1:0] ins_kind,
  input logic [OP_W-1:0]   op_bytes,
  input logic              cp_fault,
  input logic              armed
);
  logic is_pad;
  assign is_pad = (op_bytes[7:0] == 8'hF3) && (op_bytes[15:8] == 8'h0F) &&
                  (op_bytes[23:16] == 8'h1E) &&
                  (op_bytes[31:24] == (mode32 ? 8'hFB : 8'hFA));

  p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    track_en && ins_valid && !armed && (ins_kind == 3'd3 || ins_kind == 3'd4) |=> armed);
  p_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
    track_en && ins_valid && armed && is_pad |=> !armed && !cp_fault);
  p_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    track_en && ins_valid && armed && !is_pad |=> cp_fault && !armed);
  p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !armed && (ins_kind == 3'd1 || ins_kind == 3'd2) |=> !armed && !cp_fault);
  p_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !armed && (ins_kind == 3'd5 || ins_kind == 3'd0) |=> !armed && !cp_fault);
  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> !armed && !cp_fault);
  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    track_en && !ins_valid |=> $stable(armed) && !cp_fault);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |=> !cp_fault);
  p_idle_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |-> !armed);
endmodule

bind lpad_tracker lpad_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .track_en(track_en), .mode32(mode32),
  .ins_valid(ins_valid), .ins_kind(ins_kind), .op_bytes(op_bytes),
  .cp_fault(cp_fault), .armed(armed)
);

// File: tb/tb_lpad_tracker.sv
module tb_lpad_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        track_en = 1'b0, mode32 = 1'b0, ins_valid = 1'b0;
  logic [2:0]  ins_kind = 3'd0;
  logic [31:0] op_bytes = 32'd0;
  logic        cp_fault, armed;

  int total = 0, bad = 0;
  logic exp_armed = 1'b0, exp_fault = 1'b0;

  localparam logic [31:0] M64 = {8'hFA, 8'h1E, 8'h0F, 8'hF3};
  localparam logic [31:0] M32 = {8'hFB, 8'h1E, 8'h0F, 8'hF3};

  always #5 clk = ~clk;

  lpad_tracker dut (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .mode32(mode32),
    .ins_valid(ins_valid), .ins_kind(ins_kind), .op_bytes(op_bytes),
    .cp_fault(cp_fault), .armed(armed)
  );

  function automatic bit marker_ok(input logic [31:0] b, input logic w32);
    return b == (w32 ? M32 : M64);
  endfunction

  function automatic bit arms(input logic [2:0] k);
    return k == 3'd3 || k == 3'd4;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // apply one instruction at negedge, model the next state, compare at next negedge
  task automatic step(input string tag, input logic en, input logic w32,
                      input logic v, input logic [2:0] k, input logic [31:0] b);
    logic na, nf;
    track_en = en; mode32 = w32; ins_valid = v; ins_kind = k; op_bytes = b;
    na = exp_armed; nf = 1'b0;
    if (!en) na = 1'b0;
    else if (v) begin
      if (exp_armed) begin
        na = 1'b0;
        nf = !marker_ok(b, w32);
      end else na = arms(k);
    end
    @(posedge clk);
    @(negedge clk);
    exp_armed = na; exp_fault = nf;
    check({tag, " armed"}, armed, exp_armed);
    check({tag, " fault"}, cp_fault, exp_fault);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R10 armed at reset", armed, 1'b0);
    check("R10 fault at reset", cp_fault, 1'b0);
    rst_n = 1'b1;

    // R1 / R2 64-bit landing
    step("R1 icall arms", 1, 0, 1, 3'd3, 32'h0);
    step("R2 pad64 lands", 1, 0, 1, 3'd0, M64);
    step("R1 ijmp arms", 1, 0, 1, 3'd4, 32'h0);
    step("R3 non-pad faults", 1, 0, 1, 3'd0, 32'h90909090);
    step("R9 pulse ends", 1, 0, 1, 3'd0, 32'h0);
    // R4 direct, R5 return/other
    step("R4 dcall no arm", 1, 0, 1, 3'd1, 32'h0);
    step("R4 djmp no arm", 1, 0, 1, 3'd2, 32'h0);
    step("R5 ret no arm", 1, 0, 1, 3'd5, 32'h0);
    step("R5 other no arm", 1, 0, 1, 3'd0, 32'h12345678);
    step("R7 idle pad no effect", 1, 0, 1, 3'd0, M64);
    // R8 bubbles hold the wait
    step("R1 arm before bubbles", 1, 0, 1, 3'd3, 32'h0);
    step("R8 bubble holds", 1, 0, 0, 3'd0, 32'h0);
    step("R8 bubble holds 2", 1, 0, 0, 3'd4, 32'hDEADBEEF);
    step("R2 pad after bubbles", 1, 0, 1, 3'd0, M64);
    // R3 back-to-back indirect faults, no re-arm
    step("R1 arm", 1, 0, 1, 3'd4, 32'h0);
    step("R3 indirect while armed", 1, 0, 1, 3'd3, 32'h0);
    step("R9 idle after fault", 1, 0, 1, 3'd0, 32'h0);
    // R6 32-bit mode
    step("R6 arm w32", 1, 1, 1, 3'd3, 32'h0);
    step("R6 pad32 lands", 1, 1, 1, 3'd0, M32);
    step("R6 arm w32 again", 1, 1, 1, 3'd4, 32'h0);
    step("R6 pad64 faults in w32", 1, 1, 1, 3'd0, M64);
    step("R6 arm w64", 1, 0, 1, 3'd3, 32'h0);
    step("R6 pad32 faults in w64", 1, 0, 1, 3'd0, M32);
    // R7 disabled
    step("R7 disabled icall", 0, 0, 1, 3'd3, 32'h0);
    step("R7 disabled garbage", 0, 0, 1, 3'd0, 32'h11111111);
    step("R1 arm then disable", 1, 0, 1, 3'd3, 32'h0);
    step("R7 disable clears wait", 0, 0, 1, 3'd0, 32'h22222222);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic en, w32, v;
      logic [2:0] k;
      logic [31:0] b;
      int sel;
      en  = ($urandom % 10) != 0;
      w32 = ($urandom % 4) == 0;
      v   = ($urandom % 5) != 0;
      k   = 3'($urandom % 6);
      sel = $urandom % 4;
      b = (sel == 0) ? M64 : (sel == 1) ? M32 : (sel == 2) ? (M64 ^ (32'h1 << ($urandom % 32))) : $urandom;
      step("R1R2R3R6R8 random", en, w32, v, k, b);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule